// File: doc/BRIEF.md
# Dual Down-Counter Timer with 64-bit Chaining

This peripheral holds two 32-bit down-counters, each with its own load value, control bits, sticky status bit and interrupt output. Software programs it through a word-addressed register port (one access per cycle, write strobe, read strobe, address, data). The counters advance only on cycles where the count-enable input is high, so a prescaler outside the block sets the tick rate. Each counter runs either periodically, taking its load value again on expiry, or as a one-shot that stops at zero.

A mode bit chains the two counters into one 64-bit down-counter, with counter B as the upper half. In that mode a separate set of register addresses controls the chained counter, its interrupt leaves on the first interrupt output, and the second output stays low. Register writes addressed to the set that does not belong to the current mode are dropped. Reads are never gated. The register port is a plain control interface with no back-pressure: a write takes effect at the clock edge where it is presented, and read data is combinational while the read strobe is high (zero otherwise).

Top module: `dual_timer`

## Requirements
- R1: After reset both values and both load registers are 0, all control bits and status bits are 0, the mode bit is 0 (32-bit operation), every register reads 0 and both interrupt outputs are low.
- R2: In 32-bit operation counter A uses word addresses 0 to 5 and counter B uses 6 to 11. Within a counter the offsets are: +0 current value (read only), +1 load, +2 background load, +3 control (bit 0 run, bit 1 one-shot, bit 2 interrupt enable), +4 raw status in bit 0, +5 masked status (raw AND interrupt enable) in bit 0 (read only). Unused bits and unmapped addresses read 0.
- R3: A write to the load register sets both the load value and the current value at that clock edge. A write to the background load register changes only the load value; the current value is untouched.
- R4: A running counter decreases by one on each cycle with count enable high. It holds its value when count enable is low or its run bit is 0.
- R5: When a running counter at 1 receives a tick it sets its raw status bit. In periodic mode it takes the load value instead of reaching 0. A running counter that sits at 0 takes the load value on its next tick without setting status.
- R6: In one-shot mode a running counter at 1 goes to 0 on a tick, sets its raw status bit and clears its own run bit.
- R7: Writing 1 to bit 0 of a raw status register clears it and writing 0 has no effect; a status set in the same cycle wins over the clear. Each interrupt output equals its counter's raw status AND interrupt enable.
- R8: Address 12 bit 0 is the mode bit (1 = 64-bit). In 64-bit operation the counter is the concatenation {B value, A value}. Its registers are: 13 value high, 14 value low (both read only), 15 load high, 16 load low, 17 background load high, 18 background load low, 19 control, 20 raw status, 21 masked status, with the same bit meanings as R2, R3, R5 and R6. The first interrupt output carries its interrupt and the second output is held low.
- R9: While the mode bit is 1, writes to addresses 0 to 11 have no effect.
- R10: While the mode bit is 0, writes to addresses 13 to 21 have no effect.
- R11: In 64-bit operation a tick with the low half at 0 and the high half non-zero sets the low half to all ones and lowers the high half by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick, one per enabled cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| irq_a | output | 1 | Interrupt of counter A or of the chained counter |
| irq_b | output | 1 | Interrupt of counter B, low in 64-bit operation |

## Verification
The embedded properties assume one register access per cycle and that a gated write is the only traffic in its cycle, so a held load register can be checked with $stable. The count-step and borrow properties only fire on cycles without a bus write, since a load write overrides counting. The stimulus drives exactly one strobe per cycle and never switches the mode in the middle of an access, while a behavioural model in the bench tracks every register and both interrupt lines on each clock.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int BANK_STRIDE = 6;
  localparam int OFS_VAL     = 0;
  localparam int OFS_LOAD    = 1;
  localparam int OFS_BG      = 2;
  localparam int OFS_CTRL    = 3;
  localparam int OFS_RAW     = 4;
  localparam int OFS_MSK     = 5;
  localparam int ADR_MODE    = 12;
  localparam int ADR_W_VHI   = 13;
  localparam int ADR_W_VLO   = 14;
  localparam int ADR_W_LHI   = 15;
  localparam int ADR_W_LLO   = 16;
  localparam int ADR_W_BHI   = 17;
  localparam int ADR_W_BLO   = 18;
  localparam int ADR_W_CTRL  = 19;
  localparam int ADR_W_RAW   = 20;
  localparam int ADR_W_MSK   = 21;

  typedef struct packed {
    logic irq_en;
    logic oneshot;
    logic en;
  } ctl_t;
endpackage

// File: rtl/count_core.sv
`timescale 1ns/1ps
module count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic         wr_bg,
  input  logic [W-1:0] wdata,
  input  logic         do_reload,
  input  logic         do_zero,
  input  logic         do_dec,
  output logic [W-1:0] value,
  output logic [W-1:0] load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      load  <= '0;
    end else begin
      if (wr_val || wr_bg) load <= wdata;
      if (wr_val)          value <= wdata;
      else if (do_reload)  value <= load;
      else if (do_zero)    value <= '0;
      else if (do_dec)     value <= value - W'(1);
    end
  end

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> (value == $past(wdata)) && (load == $past(wdata)));

  assert_bg_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bg && !wr_val && !do_reload && !do_zero && !do_dec) |=> $stable(value));
endmodule

// File: rtl/ctl_bits.sv
`timescale 1ns/1ps
module ctl_bits
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [2:0] wbits,
  input  logic       wr_clr,
  input  logic       expire,
  input  logic       stop,
  output ctl_t       ctl,
  output logic       raw
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      raw <= 1'b0;
    end else begin
      if (wr_ctrl) ctl <= ctl_t'(wbits);
      if (stop)    ctl.en <= 1'b0;
      if (wr_clr)  raw <= 1'b0;
      if (expire)  raw <= 1'b1;
    end
  end

  assert_expire_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw);

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ctl.en);
endmodule

// File: rtl/timer_decode.sv
`timescale 1ns/1ps
module timer_decode
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NCNT   = 2
) (
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        wdata0,
  input  logic                        mode,
  input  logic [NCNT-1:0][DATA_W-1:0] val,
  input  logic [NCNT-1:0][DATA_W-1:0] ld,
  input  ctl_t [NCNT-1:0]             ctl,
  input  logic [NCNT-1:0]             raw,
  output logic [NCNT-1:0]             wr_val,
  output logic [NCNT-1:0]             wr_bg,
  output logic [NCNT-1:0]             wr_ctrl,
  output logic [NCNT-1:0]             wr_clr,
  output logic                        wr_mode,
  output logic [DATA_W-1:0]           bus_rdata
);
  logic [DATA_W-1:0] rmux;

  always_comb begin
    wr_val  = '0;
    wr_bg   = '0;
    wr_ctrl = '0;
    wr_clr  = '0;
    wr_mode = bus_wr && (bus_addr == ADDR_W'(ADR_MODE));
    if (bus_wr && !mode) begin
      for (int i = 0; i < NCNT; i++) begin
        if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_LOAD)) wr_val[i]  = 1'b1;
        if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_BG))   wr_bg[i]   = 1'b1;
        if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_CTRL)) wr_ctrl[i] = 1'b1;
        if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_RAW))  wr_clr[i]  = wdata0;
      end
    end
    if (bus_wr && mode) begin
      if (bus_addr == ADDR_W'(ADR_W_LHI))  wr_val[1]  = 1'b1;
      if (bus_addr == ADDR_W'(ADR_W_LLO))  wr_val[0]  = 1'b1;
      if (bus_addr == ADDR_W'(ADR_W_BHI))  wr_bg[1]   = 1'b1;
      if (bus_addr == ADDR_W'(ADR_W_BLO))  wr_bg[0]   = 1'b1;
      if (bus_addr == ADDR_W'(ADR_W_CTRL)) wr_ctrl[0] = 1'b1;
      if (bus_addr == ADDR_W'(ADR_W_RAW))  wr_clr[0]  = wdata0;
    end
  end

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_VAL))  rmux = val[i];
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_LOAD)) rmux = ld[i];
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_BG))   rmux = ld[i];
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_CTRL)) rmux = DATA_W'(ctl[i]);
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_RAW))  rmux = DATA_W'(raw[i]);
      if (bus_addr == ADDR_W'(i*BANK_STRIDE + OFS_MSK))  rmux = DATA_W'(raw[i] & ctl[i].irq_en);
    end
    case (bus_addr)
      ADDR_W'(ADR_MODE):   rmux = DATA_W'(mode);
      ADDR_W'(ADR_W_VHI):  rmux = val[1];
      ADDR_W'(ADR_W_VLO):  rmux = val[0];
      ADDR_W'(ADR_W_LHI):  rmux = ld[1];
      ADDR_W'(ADR_W_LLO):  rmux = ld[0];
      ADDR_W'(ADR_W_BHI):  rmux = ld[1];
      ADDR_W'(ADR_W_BLO):  rmux = ld[0];
      ADDR_W'(ADR_W_CTRL): rmux = DATA_W'(ctl[0]);
      ADDR_W'(ADR_W_RAW):  rmux = DATA_W'(raw[0]);
      ADDR_W'(ADR_W_MSK):  rmux = DATA_W'(raw[0] & ctl[0].irq_en);
      default: ;
    endcase
  end

  assign bus_rdata = bus_rd ? rmux : '0;
endmodule

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int NCNT   = 2;
  localparam int WIDE_W = NCNT * DATA_W;

  logic                        mode_q;
  logic [NCNT-1:0][DATA_W-1:0] val, ld;
  ctl_t [NCNT-1:0]             ctl;
  logic [NCNT-1:0]             raw;
  logic [NCNT-1:0]             wr_val, wr_bg, wr_ctrl, wr_clr;
  logic                        wr_mode;
  logic [NCNT-1:0]             do_reload, do_zero, do_dec, expire, stop;
  logic [WIDE_W-1:0]           wide_val;
  logic                        wide_one, wide_zero, run64;

  timer_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCNT(NCNT)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .wdata0(bus_wdata[0]),
    .mode(mode_q), .val(val), .ld(ld), .ctl(ctl), .raw(raw),
    .wr_val(wr_val), .wr_bg(wr_bg), .wr_ctrl(wr_ctrl), .wr_clr(wr_clr),
    .wr_mode(wr_mode), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (wr_mode) mode_q <= bus_wdata[0];
  end

  assign wide_val  = {val[1], val[0]};
  assign wide_one  = (wide_val == WIDE_W'(1));
  assign wide_zero = (wide_val == '0);
  assign run64     = mode_q & ctl[0].en & cnt_en & ~(|wr_val);

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic run32, is1, is0, dec_ok;
    assign run32 = ~mode_q & ctl[i].en & cnt_en & ~wr_val[i];
    assign is1   = (val[i] == DATA_W'(1));
    assign is0   = (val[i] == '0);

    if (i == 0) begin : g_lo
      assign dec_ok    = 1'b1;
      assign expire[i] = mode_q ? (run64 & wide_one) : (run32 & is1);
    end else begin : g_hi
      assign dec_ok    = (val[0] == '0);
      assign expire[i] = run32 & is1;
    end

    assign do_reload[i] = mode_q ? (run64 & ((wide_one & ~ctl[0].oneshot) | wide_zero))
                                 : (run32 & ((is1 & ~ctl[i].oneshot) | is0));
    assign do_zero[i]   = mode_q ? (run64 & wide_one & ctl[0].oneshot)
                                 : (run32 & is1 & ctl[i].oneshot);
    assign do_dec[i]    = mode_q ? (run64 & ~wide_one & ~wide_zero & dec_ok)
                                 : (run32 & ~is1 & ~is0);
    assign stop[i]      = expire[i] & ctl[i].oneshot;

    count_core #(.W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .wr_val(wr_val[i]), .wr_bg(wr_bg[i]),
      .wdata(bus_wdata), .do_reload(do_reload[i]), .do_zero(do_zero[i]),
      .do_dec(do_dec[i]), .value(val[i]), .load(ld[i])
    );

    ctl_bits u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl[i]), .wbits(bus_wdata[2:0]),
      .wr_clr(wr_clr[i]), .expire(expire[i]), .stop(stop[i]),
      .ctl(ctl[i]), .raw(raw[i])
    );
  end

  assign irq_a = raw[0] & ctl[0].irq_en;
  assign irq_b = ~mode_q & raw[1] & ctl[1].irq_en;

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && ctl[0].en && cnt_en && val[0] > DATA_W'(1) && !bus_wr)
    |=> val[0] == $past(val[0]) - DATA_W'(1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !bus_wr) |=> $stable(val));

  assert_hi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $past(mode_q)) |-> !$rose(raw[1]));

  assert_gate32_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && bus_wr && bus_addr == ADDR_W'(OFS_LOAD)) |=> $stable(ld[0]));

  assert_gate64_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && bus_wr && bus_addr == ADDR_W'(ADR_W_LLO)) |=> $stable(ld[0]));

  assert_borrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run64 && val[0] == '0 && val[1] != '0 && !bus_wr)
    |=> (val[0] == '1) && (val[1] == $past(val[1]) - DATA_W'(1)));
endmodule

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit        m_mode;
  bit [31:0] m_v[2];
  bit [31:0] m_l[2];
  bit        m_en[2], m_os[2], m_ie[2], m_rw[2];

  dual_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  always #2.5 clk = ~clk;

  function automatic bit [31:0] mread(int a);
    int i;
    if (a < 12) begin
      i = a / 6;
      case (a % 6)
        0: return m_v[i];
        1, 2: return m_l[i];
        3: return {29'd0, m_ie[i], m_os[i], m_en[i]};
        4: return {31'd0, m_rw[i]};
        default: return {31'd0, m_rw[i] & m_ie[i]};
      endcase
    end
    case (a)
      12: return {31'd0, m_mode};
      13, 15, 17: return (a == 13) ? m_v[1] : m_l[1];
      14, 16, 18: return (a == 14) ? m_v[0] : m_l[0];
      19: return {29'd0, m_ie[0], m_os[0], m_en[0]};
      20: return {31'd0, m_rw[0]};
      21: return {31'd0, m_rw[0] & m_ie[0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0;
    for (int i = 0; i < 2; i++) begin
      m_v[i] = 0; m_l[i] = 0; m_en[i] = 0; m_os[i] = 0; m_ie[i] = 0; m_rw[i] = 0;
    end
  endtask

  // one clock: inputs already driven at negedge
  task automatic step();
    bit        n_mode;
    bit [31:0] n_v[2], n_l[2];
    bit        n_en[2], n_os[2], n_ie[2], n_rw[2];
    bit        lw[2];
    int        a;
    longint unsigned wv, wl;
    #1;
    if (bus_rd) check(cur_tag, bus_rdata, mread(bus_addr));
    a = bus_addr;
    n_mode = m_mode;
    for (int i = 0; i < 2; i++) begin
      n_v[i] = m_v[i]; n_l[i] = m_l[i]; n_en[i] = m_en[i];
      n_os[i] = m_os[i]; n_ie[i] = m_ie[i]; n_rw[i] = m_rw[i]; lw[i] = 0;
    end
    if (bus_wr) begin
      if (a == 12) n_mode = bus_wdata[0];
      if (!m_mode && a < 12) begin
        int i = a / 6;
        case (a % 6)
          1: begin n_l[i] = bus_wdata; n_v[i] = bus_wdata; lw[i] = 1; end
          2: n_l[i] = bus_wdata;
          3: begin n_en[i] = bus_wdata[0]; n_os[i] = bus_wdata[1]; n_ie[i] = bus_wdata[2]; end
          4: if (bus_wdata[0]) n_rw[i] = 0;
          default: ;
        endcase
      end
      if (m_mode) begin
        case (a)
          15: begin n_l[1] = bus_wdata; n_v[1] = bus_wdata; lw[1] = 1; end
          16: begin n_l[0] = bus_wdata; n_v[0] = bus_wdata; lw[0] = 1; end
          17: n_l[1] = bus_wdata;
          18: n_l[0] = bus_wdata;
          19: begin n_en[0] = bus_wdata[0]; n_os[0] = bus_wdata[1]; n_ie[0] = bus_wdata[2]; end
          20: if (bus_wdata[0]) n_rw[0] = 0;
          default: ;
        endcase
      end
    end
    if (cnt_en) begin
      if (!m_mode) begin
        for (int i = 0; i < 2; i++) begin
          if (m_en[i] && !lw[i]) begin
            if (m_v[i] == 1) begin
              n_rw[i] = 1;
              if (m_os[i]) begin n_v[i] = 0; n_en[i] = 0; end
              else n_v[i] = m_l[i];
            end else if (m_v[i] == 0) n_v[i] = m_l[i];
            else n_v[i] = m_v[i] - 1;
          end
        end
      end else if (m_en[0] && !lw[0] && !lw[1]) begin
        wv = {m_v[1], m_v[0]};
        wl = {m_l[1], m_l[0]};
        if (wv == 1) begin
          n_rw[0] = 1;
          if (m_os[0]) begin wv = 0; n_en[0] = 0; end
          else wv = wl;
        end else if (wv == 0) wv = wl;
        else wv = wv - 1;
        n_v[1] = wv[63:32];
        n_v[0] = wv[31:0];
      end
    end
    @(posedge clk);
    cycles++;
    m_mode = n_mode;
    for (int i = 0; i < 2; i++) begin
      m_v[i] = n_v[i]; m_l[i] = n_l[i]; m_en[i] = n_en[i];
      m_os[i] = n_os[i]; m_ie[i] = n_ie[i]; m_rw[i] = n_rw[i];
    end
    @(negedge clk);
    check("R7 irq_a", irq_a, m_rw[0] & m_ie[0]);
    check("R8 irq_b", irq_b, m_mode ? 1'b0 : (m_rw[1] & m_ie[1]));
  endtask

  task automatic wr(int a, bit [31:0] d);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(int a, string tag);
    bus_rd = 1; bus_addr = 5'(a); cur_tag = tag;
    step();
    bus_rd = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq_a reset", irq_a, 0);
    check("R1 irq_b reset", irq_b, 0);
    for (int a = 0; a < 24; a++) rd(a, "R1 R2 reset read");

    cnt_en = 1;
    wr(1, 5);
    rd(0, "R3 load copied");
    wr(3, 5);
    idle(12);
    rd(0, "R4 counting");
    rd(4, "R5 raw set");
    rd(5, "R7 masked");
    cnt_en = 0;
    idle(3);
    rd(0, "R4 hold");
    cnt_en = 1;
    wr(2, 3);
    rd(0, "R3 bg keeps value");
    rd(2, "R3 bg load");
    idle(10);
    rd(0, "R5 periodic reload");
    wr(4, 0);
    rd(4, "R7 zero write ignored");
    wr(4, 1);
    rd(4, "R7 cleared");

    wr(7, 3);
    wr(9, 7);
    idle(6);
    rd(9, "R6 run bit cleared");
    rd(6, "R6 value at zero");
    rd(10, "R6 raw set");
    idle(3);
    rd(6, "R6 stays zero");
    wr(3, 0);
    wr(10, 1);
    wr(4, 1);

    wr(12, 1);
    rd(12, "R8 mode set");
    wr(1, 99);
    rd(1, "R9 load ignored");
    wr(9, 7);
    rd(9, "R9 ctrl ignored");
    wr(15, 1);
    wr(16, 2);
    wr(19, 5);
    idle(1);
    rd(14, "R11 low half");
    rd(13, "R11 high half");
    rd(14, "R11 borrow low");
    rd(13, "R11 borrow high");
    wr(19, 0);
    wr(15, 0);
    wr(16, 4);
    wr(19, 7);
    idle(8);
    rd(19, "R8 one-shot stop");
    rd(20, "R8 raw");
    rd(14, "R8 value zero");
    wr(20, 1);
    wr(17, 0);
    wr(18, 3);
    wr(15, 0);
    wr(16, 3);
    wr(19, 5);
    idle(10);
    rd(14, "R8 periodic reload");
    rd(21, "R8 masked");

    wr(12, 0);
    wr(16, 77);
    rd(16, "R10 load ignored");
    rd(0, "R10 value kept");
    wr(19, 0);
    rd(3, "R10 ctrl kept");
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule